// File: doc/BRIEF.md
# Mode-Selectable Decimating FIR Pair

This block filters a stream of complex samples that arrives from an upstream decimator. It has two FIR paths, one for the in-phase (I) stream and one for the quadrature (Q) stream. Both paths read the same programmable set of signed fixed-point coefficients. Each path keeps its recent input samples in a tap line. A full multiply-accumulate pass over the taps runs only at a decimated output instant. In that pass one product per path is summed in each cycle, and the sum is saturated to a 38-bit result.

A plain mode input selects how the block behaves. In complex mode both paths run and each emits one result per four accepted samples. In real mode only the I path runs and emits one result per two samples. In filter-only mode only the I path runs and emits one result per four samples. An inactive Q path keeps its output at zero and never raises its valid strobe. A change of mode flushes the block. The decimation phase returns to zero, both tap lines are cleared, and a running pass or an unaccepted result is dropped. The first result after the change is therefore built only from new samples.

The input and output streams use valid/ready handshakes. A sample transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low in three cases: while a pass runs, while a result waits with `out_ready` low, and in the single cycle in which `mode` differs from the mode in use. A result transfers on an edge where `out_valid_i` and `out_ready` are both high. It holds steady until it transfers. A new sample may be taken on the same edge as the pending result.

Top module: `fir_pair_top`

## Requirements
- R1: After reset `out_valid_i` and `out_valid_q` are low, `out_i` and `out_q` are zero, and `in_ready` is high with `mode` unchanged. All coefficients and tap contents are zero.
- R2: With mode 2'b00 (complex), every fourth accepted sample starts a pass. When the pass ends, both valid strobes rise together with `out_i = sat(sum c[k]*xi[k])` and `out_q = sat(sum c[k]*xq[k])`, where x[0] is the newest sample and x[k] the one accepted k samples earlier.
- R3: With mode 2'b01 (real), every second accepted sample produces an I result. `out_valid_q` stays low and `out_q` stays zero.
- R4: With mode 2'b10 (filter-only), and with the reserved code 2'b11 that behaves the same way, every fourth accepted sample produces an I result. Q stays inactive as in R3.
- R5: Samples are 16-bit signed integers scaled by 2^-15, and coefficients are 22-bit signed integers scaled by 2^-22. A result is the integer sum of products, scaled by 2^-37, saturated to the range -2^37 .. 2^37-1.
- R6: When `mode` differs from the mode in use, `in_ready` is low for one cycle. The edge that closes that cycle clears the decimation phase and both tap lines, aborts any pass and drops any pending result.
- R7: `in_ready` is low during a pass and while a result is pending with `out_ready` low. A pending result with `out_ready` low keeps its valid strobes and data stable.
- R8: `out_valid_i` rises after the TAPS-th rising edge that follows the edge accepting the sample at the output instant (16 edges at the default).
- R9: A write with `coef_we` high stores `coef_data` at tap `coef_addr` on the clock edge. The single stored set is used by both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 complex, 01 real, 10 filter-only, 11 as filter-only |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Tap index to write |
| coef_data | input | 22 | Signed coefficient value |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | 16 | I sample, signed |
| in_q | input | 16 | Q sample, signed |
| out_ready | input | 1 | Consumer can take a result |
| out_valid_i | output | 1 | I result valid |
| out_valid_q | output | 1 | Q result valid (complex mode only) |
| out_i | output | 38 | I result, signed |
| out_q | output | 38 | Q result, signed, zero when inactive |

## Verification
Two pairs of events can fall in the same cycle. The first pair is taking a pending result and accepting a new sample. This happens in every back-to-back run of the vector table, because the consumer stays ready and the next sample waits on the pass. A reference model that keeps its own history and phase judges every result in those runs. The second pair is a mode flush and a running pass. It is provoked by changing the mode a few cycles into a pass. The bench then requires no result for longer than a pass, and it requires that the next result, in the new mode, is built only from samples sent after the change.

// File: rtl/fir_pair_pkg.sv
package fir_pair_pkg;
  typedef enum logic [1:0] {
    MODE_CPLX = 2'b00,
    MODE_REAL = 2'b01,
    MODE_FILT = 2'b10,
    MODE_RSVD = 2'b11
  } fir_mode_e;
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int TAPS   = 16,
  parameter int COEF_W = 22,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [COEF_W-1:0] rd_coef
);
  logic [COEF_W-1:0] bank [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) bank[k] <= '0;
    end else if (wr_en) begin
      bank[wr_addr] <= wr_data;
    end
  end

  assign rd_coef = bank[rd_idx];
endmodule

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int TAPS   = 16,
  parameter int SAMP_W = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [SAMP_W-1:0] din,
  input  logic [AW-1:0]     rd_idx,
  output logic [SAMP_W-1:0] rd_data
);
  logic [SAMP_W-1:0] line [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) line[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < TAPS; k++) line[k] <= '0;
    end else if (shift) begin
      line[0] <= din;
      for (int k = 1; k < TAPS; k++) line[k] <= line[k-1];
    end
  end

  assign rd_data = line[rd_idx];
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int SAMP_W = 16,
  parameter int COEF_W = 22,
  parameter int OUT_W  = 38,
  parameter int ACC_W  = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [SAMP_W-1:0] sample,
  input  logic [COEF_W-1:0] coef,
  output logic [OUT_W-1:0]  sat_out
);
  localparam int PROD_W = SAMP_W + COEF_W;
  localparam logic signed [ACC_W-1:0] MAXV =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  acc, acc_nxt;
  logic signed [PROD_W-1:0] prod;

  assign prod    = $signed(sample) * $signed(coef);
  assign acc_nxt = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (clr)  acc <= '0;
    else if (step) acc <= acc_nxt;
  end

  always_comb begin
    if (acc_nxt > MAXV)      sat_out = MAXV[OUT_W-1:0];
    else if (acc_nxt < MINV) sat_out = MINV[OUT_W-1:0];
    else                     sat_out = acc_nxt[OUT_W-1:0];
  end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pair_pkg::*;
#(
  parameter int TAPS = 16,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          accept,
  output logic          start,
  output logic          mode_chg,
  output logic          q_act,
  output logic          busy,
  output logic          last,
  output logic [AW-1:0] idx,
  output logic          out_pend,
  output logic [1:0]    mode_q
);
  logic [1:0] phase;
  logic [1:0] phase_end;

  assign mode_chg  = (mode != mode_q);
  assign q_act     = (mode_q == MODE_CPLX);
  assign phase_end = (mode_q == MODE_REAL) ? 2'd1 : 2'd3;
  assign in_ready  = !mode_chg && !busy && (!out_pend || out_ready);
  assign accept    = in_valid && in_ready;
  assign start     = accept && (phase == phase_end);
  assign last      = busy && (idx == AW'(TAPS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_CPLX;
      phase    <= '0;
      busy     <= 1'b0;
      idx      <= '0;
      out_pend <= 1'b0;
    end else if (mode_chg) begin
      mode_q   <= mode;
      phase    <= '0;
      busy     <= 1'b0;
      idx      <= '0;
      out_pend <= 1'b0;
    end else begin
      if (accept) phase <= (phase == phase_end) ? 2'd0 : phase + 2'd1;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        idx <= idx + AW'(1);
        if (last) busy <= 1'b0;
      end
      if (last)                      out_pend <= 1'b1;
      else if (out_pend && out_ready) out_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fir_pair_top.sv
module fir_pair_top
  import fir_pair_pkg::*;
#(
  parameter int TAPS   = 16,
  parameter int SAMP_W = 16,
  parameter int COEF_W = 22,
  parameter int OUT_W  = 38,
  localparam int AW    = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              coef_we,
  input  logic [AW-1:0]     coef_addr,
  input  logic [COEF_W-1:0] coef_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_i,
  input  logic [SAMP_W-1:0] in_q,
  input  logic              out_ready,
  output logic              out_valid_i,
  output logic              out_valid_q,
  output logic [OUT_W-1:0]  out_i,
  output logic [OUT_W-1:0]  out_q
);
  localparam int NPATH = 2;
  localparam int ACC_W = SAMP_W + COEF_W + AW;

  logic          accept, start, mode_chg, q_act, busy, last, out_pend;
  logic [AW-1:0] idx;
  logic [1:0]    mode_q;
  logic [COEF_W-1:0] cur_coef;
  logic [SAMP_W-1:0] path_din [NPATH];
  logic [SAMP_W-1:0] path_tap [NPATH];
  logic [OUT_W-1:0]  path_sat [NPATH];
  logic              path_shift [NPATH];
  logic [OUT_W-1:0]  res_i, res_q;

  fir_ctrl #(.TAPS(TAPS), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .out_ready(out_ready), .in_ready(in_ready), .accept(accept),
    .start(start), .mode_chg(mode_chg), .q_act(q_act), .busy(busy),
    .last(last), .idx(idx), .out_pend(out_pend), .mode_q(mode_q)
  );

  fir_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W), .AW(AW)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_addr(coef_addr),
    .wr_data(coef_data), .rd_idx(idx), .rd_coef(cur_coef)
  );

  assign path_din[0]   = in_i;
  assign path_din[1]   = in_q;
  assign path_shift[0] = accept;
  assign path_shift[1] = accept && q_act;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    fir_tap_line #(.TAPS(TAPS), .SAMP_W(SAMP_W), .AW(AW)) u_line (
      .clk(clk), .rst_n(rst_n), .clr(mode_chg), .shift(path_shift[g]),
      .din(path_din[g]), .rd_idx(idx), .rd_data(path_tap[g])
    );
    fir_mac #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(start), .step(busy),
      .sample(path_tap[g]), .coef(cur_coef), .sat_out(path_sat[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_i <= '0;
      res_q <= '0;
    end else if (mode_chg) begin
      res_i <= '0;
      res_q <= '0;
    end else if (last) begin
      res_i <= path_sat[0];
      res_q <= q_act ? path_sat[1] : '0;
    end
  end

  assign out_valid_i = out_pend;
  assign out_valid_q = out_pend && q_act;
  assign out_i       = res_i;
  assign out_q       = res_q;
endmodule

// File: rtl/fir_pair_chk.sv
module fir_pair_chk #(
  parameter int OUT_W = 38
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [1:0]       mode_q,
  input logic             busy,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_valid_i,
  input logic             out_valid_q,
  input logic [OUT_W-1:0] out_i,
  input logic [OUT_W-1:0] out_q
);
  assert_q_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00) |-> (!out_valid_q && out_q == '0));

  assert_q_pairs_i_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_q |-> out_valid_i);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_i && !out_ready && mode == mode_q) |=>
      (out_valid_i && $stable(out_i) && $stable(out_q)));

  assert_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_i && !out_ready) |-> !in_ready);

  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (!out_valid_i && !busy));

  assert_pass_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid_i);
endmodule

bind fir_pair_top fir_pair_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mode_q(mode_q), .busy(busy),
  .in_ready(in_ready), .out_ready(out_ready), .out_valid_i(out_valid_i),
  .out_valid_q(out_valid_q), .out_i(out_i), .out_q(out_q)
);

// File: tb/tb_fir_pair_top.sv
`timescale 1ns/1ps
module tb_fir_pair_top;
  localparam int TAPS = 16;
  localparam int NV   = 24;
  localparam longint SMAX = (longint'(1) <<< 37) - 1;
  localparam longint SMIN = -(longint'(1) <<< 37);

  // {mode, I sample, Q sample}
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 16'h1000, 16'hF000}, {2'b00, 16'h7FFF, 16'h0001},
    {2'b00, 16'h8000, 16'h2345}, {2'b00, 16'h0123, 16'hFEDC},
    {2'b00, 16'h3A00, 16'hC600}, {2'b00, 16'h0000, 16'h7000},
    {2'b00, 16'hFFFF, 16'h0010}, {2'b00, 16'h2222, 16'hDDDD},
    {2'b01, 16'h4000, 16'h1111}, {2'b01, 16'hC000, 16'h2222},
    {2'b01, 16'h0F0F, 16'h3333}, {2'b01, 16'h7000, 16'h4444},
    {2'b01, 16'h9000, 16'h5555}, {2'b01, 16'h0055, 16'h6666},
    {2'b10, 16'h1234, 16'h0F00}, {2'b10, 16'h5678, 16'h0F00},
    {2'b10, 16'hA5A5, 16'h0F00}, {2'b10, 16'h0101, 16'h0F00},
    {2'b10, 16'h6000, 16'h0F00}, {2'b10, 16'hE000, 16'h0F00},
    {2'b11, 16'h0800, 16'h7777}, {2'b11, 16'hF800, 16'h7777},
    {2'b11, 16'h7FFF, 16'h7777}, {2'b11, 16'h8001, 16'h7777}
  };

  logic        clk = 0, rst_n = 0;
  logic [1:0]  mode = 2'b00;
  logic        coef_we = 0;
  logic [3:0]  coef_addr = '0;
  logic [21:0] coef_data = '0;
  logic        in_valid = 0, in_ready, out_ready = 1;
  logic [15:0] in_i = '0, in_q = '0;
  logic        out_valid_i, out_valid_q;
  logic [37:0] out_i, out_q;

  int checks = 0, errors = 0, outs_seen = 0;
  int coef_m [TAPS];
  int hi [TAPS], hq [TAPS];
  int ph;
  logic [1:0] mm;
  longint eq_i [$], eq_q [$];
  bit     eq_v [$];
  longint last_i, last_q;
  bit done = 0;

  fir_pair_top dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .out_ready(out_ready),
    .out_valid_i(out_valid_i), .out_valid_q(out_valid_q),
    .out_i(out_i), .out_q(out_q)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic model_reset(input logic [1:0] m);
    for (int k = 0; k < TAPS; k++) begin hi[k] = 0; hq[k] = 0; end
    ph = 0; mm = m;
    eq_i.delete(); eq_q.delete(); eq_v.delete();
  endtask

  task automatic model_accept(input logic [15:0] i, input logic [15:0] q);
    int lastph;
    longint si, sq;
    for (int k = TAPS-1; k > 0; k--) hi[k] = hi[k-1];
    hi[0] = int'($signed(i));
    if (mm == 2'b00) begin
      for (int k = TAPS-1; k > 0; k--) hq[k] = hq[k-1];
      hq[0] = int'($signed(q));
    end
    lastph = (mm == 2'b01) ? 1 : 3;
    if (ph == lastph) begin
      ph = 0; si = 0; sq = 0;
      for (int k = 0; k < TAPS; k++) begin
        si += longint'(coef_m[k]) * longint'(hi[k]);
        sq += longint'(coef_m[k]) * longint'(hq[k]);
      end
      eq_i.push_back(sat(si));
      eq_q.push_back((mm == 2'b00) ? sat(sq) : 0);
      eq_v.push_back(mm == 2'b00);
    end else ph++;
  endtask

  task automatic wcoef(input int a, input int v);
    @(negedge clk);
    coef_we = 1; coef_addr = 4'(a); coef_data = 22'(v);
    @(posedge clk); #1;
    coef_we = 0;
    coef_m[a] = v;
  endtask

  task automatic send(input logic [15:0] i, input logic [15:0] q);
    @(negedge clk);
    in_valid = 1; in_i = i; in_q = q;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
    model_accept(i, q);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    @(posedge clk); #1;
    model_reset(m);
  endtask

  task automatic fresh(input logic [1:0] m);
    repeat (TAPS + 4) @(posedge clk);
    set_mode(m ^ 2'b01);
    set_mode(m);
  endtask

  // Result monitor: every transfer is compared with the model
  always @(negedge clk) begin
    if (rst_n && out_valid_i && out_ready) begin
      outs_seen++;
      last_i = longint'($signed(out_i));
      last_q = longint'($signed(out_q));
      if (eq_i.size() == 0) begin
        chk(0, "R6 unexpected result", last_i, 0);
      end else begin
        longint ei, eqv;
        bit ev;
        ei = eq_i.pop_front(); eqv = eq_q.pop_front(); ev = eq_v.pop_front();
        chk(last_i == ei, "R2/R3/R4/R5 out_i", last_i, ei);
        chk(out_valid_q == ev, "R2/R3/R4 out_valid_q", longint'(out_valid_q), longint'(ev));
        chk(last_q == eqv, "R2/R3/R5 out_q", last_q, eqv);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n0;
    model_reset(2'b00);
    for (int k = 0; k < TAPS; k++) coef_m[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(out_valid_i == 0 && out_valid_q == 0, "R1 valids", longint'(out_valid_i), 0);
    chk(out_i == '0 && out_q == '0, "R1 data zero", longint'(out_i), 0);
    @(negedge clk); rst_n = 1;
    #1;
    chk(in_ready == 1, "R1 in_ready", longint'(in_ready), 1);

    // R9: load shared coefficient set
    for (int k = 0; k < TAPS; k++)
      wcoef(k, ((k % 2) == 0) ? (k + 1) * 37000 : -(k + 1) * 37000);

    // Vector table walk; mode changes flush the model (R6)
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][33:32] != mode) begin
        repeat (TAPS + 4) @(posedge clk);
        set_mode(VEC[v][33:32]);
      end
      send(VEC[v][31:16], VEC[v][15:0]);
    end
    repeat (TAPS + 4) @(posedge clk);

    // R8 latency and R7 in_ready during pass
    fresh(2'b00);
    for (int s = 0; s < 3; s++) send(16'(s * 1000 + 77), 16'(s * 500 - 300));
    send(16'h1357, 16'h2468);
    for (int k = 1; k <= TAPS; k++) begin
      @(posedge clk); #1;
      if (k == TAPS - 1) begin
        chk(out_valid_i == 0, "R8 not yet valid", longint'(out_valid_i), 0);
        chk(in_ready == 0, "R7 in_ready low in pass", longint'(in_ready), 0);
      end
      if (k == TAPS) chk(out_valid_i == 1, "R8 valid after TAPS edges", longint'(out_valid_i), 1);
    end

    // R7 back-pressure: pending result held stable
    fresh(2'b00);
    out_ready = 0;
    for (int s = 0; s < 4; s++) send(16'(s * 3000 + 5), 16'(-s * 2000 - 9));
    repeat (TAPS + 4) @(posedge clk);
    #1;
    begin
      logic [37:0] hold_i;
      hold_i = out_i;
      chk(out_valid_i == 1, "R7 pending valid", longint'(out_valid_i), 1);
      chk(in_ready == 0, "R7 in_ready low while pending", longint'(in_ready), 0);
      repeat (5) @(posedge clk);
      #1;
      chk(out_i == hold_i && out_valid_i, "R7 data stable", longint'($signed(out_i)), longint'($signed(hold_i)));
    end
    @(negedge clk); out_ready = 1;
    repeat (3) @(posedge clk);

    // R5 saturation at both limits
    for (int k = 0; k < TAPS; k++) wcoef(k, 2097151);
    fresh(2'b00);
    for (int s = 0; s < TAPS; s++) send(16'h7FFF, 16'h8000);
    repeat (TAPS + 4) @(posedge clk);
    chk(last_i == SMAX, "R5 positive saturation", last_i, SMAX);
    chk(last_q == SMIN, "R5 negative saturation", last_q, SMIN);

    // R6 flush during a pass, then fresh history in real mode
    for (int k = 0; k < TAPS; k++) wcoef(k, (k + 1) * 1000);
    fresh(2'b00);
    for (int s = 0; s < 4; s++) send(16'h4000, 16'h4000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    mode = 2'b01;
    #1;
    chk(in_ready == 0, "R6 in_ready low on change", longint'(in_ready), 0);
    @(posedge clk); #1;
    model_reset(2'b01);
    n0 = outs_seen;
    repeat (TAPS + 4) @(posedge clk);
    chk(outs_seen == n0, "R6 aborted pass gives no result", longint'(outs_seen - n0), 0);
    send(16'h0100, 16'h7FFF);
    send(16'h0200, 16'h7FFF);
    repeat (TAPS + 4) @(posedge clk);
    // newest 0x200 * c0 + 0x100 * c1 with zeroed history (R6)
    chk(last_i == 512 * 1000 + 256 * 2000, "R6 fresh data after change", last_i, 512 * 1000 + 256 * 2000);
    chk(last_q == 0, "R3 q zero in real mode", last_q, 0);

    chk(eq_i.size() == 0, "R2 all expected results seen", longint'(eq_i.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule